// File: doc/BRIEF.md
# SPI Word-Packing Data FIFO

This block sits between a 32-bit host register port and a byte-wide serial engine, and holds the data for both directions of an SPI transfer. On the transmit side the host pushes 32-bit words into an eight-word queue. An unpacker state machine splits each word into bytes and hands them one at a time to the engine over a valid/ready handshake. On the receive side a packer state machine gathers the bytes that the engine delivers, builds 32-bit words and pushes them into a second eight-word queue. The host drains that queue through a first-word-fall-through read port.

Each direction has two independent controls. One picks the bit order inside a byte; the engine always shifts bit 7 of the byte it is given first. The other picks the byte-lane order inside a word. A transfer is started with a byte length. The unpacker emits exactly that many bytes and drops the unused lanes of a final partial word. The packer pushes a final partial word as soon as its last byte arrives. A flush input empties both queues and returns both state machines to idle.

Unpacker states: TX_IDLE (no transfer), TX_FETCH (pop the next word, or go to TX_IDLE when the length is used up) and TX_SHIFT (present the current lane). Transitions: TX_IDLE→TX_FETCH on start; TX_FETCH→TX_SHIFT on a pop; TX_FETCH→TX_IDLE when no bytes remain; TX_SHIFT→TX_FETCH when the last lane or the last byte is taken. Packer states: RX_IDLE and RX_GATHER. Transitions: RX_IDLE→RX_GATHER on start; RX_GATHER→RX_IDLE when the final byte is taken or the length is zero. A flush from any state leads to the idle state. A start from any state reloads the length.

Top module: `spi_word_packer`

## Requirements
- R1: After reset or a one-cycle flush: tx_full=0, rx_empty=1, tx_overflow=0, tx_byte_valid=0 and rx_rd_data=0.
- R2: The transmit queue holds 8 words and raises tx_full after the eighth write. A write while tx_full is high is dropped and never reaches tx_byte. It also sets tx_overflow, which stays high until reset or flush.
- R3: A read with rx_rd_en while rx_empty is high returns rx_rd_data=0 and leaves rx_empty high.
- R4: Transmit byte k of a transfer comes from word bits [8m+7:8m]. With tx_swap=0, m = k mod 4. With tx_swap=1, m = 3 - (k mod 4).
- R5: With tx_msb_first=1, tx_byte equals the selected byte unchanged. With tx_msb_first=0, it is that byte bit-reversed (byte bit 0 at tx_byte[7]).
- R6: After xfer_start with length N, exactly N bytes are presented. tx_byte_valid holds until tx_byte_ready is high. Unused lanes of the final partial word are discarded, so the next transfer begins with the next queued word.
- R7: Received byte k is placed at word bits [8m+7:8m], with m = k mod 4 when rx_swap=0 and m = 3 - (k mod 4) when rx_swap=1.
- R8: With rx_msb_first=1, rx_byte is stored unchanged. With rx_msb_first=0, it is stored bit-reversed.
- R9: When N is not a multiple of 4, the final received word is pushed right after the last byte. Its unfilled lanes read as zero; with rx_swap=0 the valid bytes sit in the low-order lanes.
- R10: A flush during a transfer empties both queues, clears tx_overflow, and drops tx_byte_valid on the next cycle.
- R11: rx_byte_valid while no transfer is active adds nothing to the receive queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of both queues and both state machines |
| xfer_start | input | 1 | Begin a transfer of xfer_len bytes in both directions |
| xfer_len | input | LEN_W | Transfer length in bytes |
| tx_msb_first | input | 1 | Transmit bit order: 1 = stored bit 7 first |
| tx_swap | input | 1 | Transmit lane order reversal |
| rx_msb_first | input | 1 | Receive bit order: 1 = first bit lands in bit 7 |
| rx_swap | input | 1 | Receive lane order reversal |
| tx_wr_en | input | 1 | Host word write strobe |
| tx_wr_data | input | 32 | Host write word |
| tx_full | output | 1 | Transmit queue full |
| tx_overflow | output | 1 | Sticky flag: write while full |
| rx_rd_en | input | 1 | Host word read strobe (pops the head) |
| rx_rd_data | output | 32 | Head of the receive queue, zero when empty |
| rx_empty | output | 1 | Receive queue empty |
| tx_byte | output | 8 | Byte for the serial engine, bit 7 shifted first |
| tx_byte_valid | output | 1 | tx_byte is valid |
| tx_byte_ready | input | 1 | Engine takes tx_byte |
| rx_byte | input | 8 | Byte assembled by the engine, first bit in bit 7 |
| rx_byte_valid | input | 1 | rx_byte is valid |

## Verification
The main function is tried with lengths of 1, 5, 7, 8, 10 and 32 bytes, each paired with a different mix of bit-order and lane-order settings in the two directions. The single-byte and 5/7/10-byte cases expose partial-word handling: discarded transmit lanes and zero-filled receive lanes. The 32-byte case fills the queue exactly. Because transmit and receive settings differ within one run, a swap of the two directions' controls is caught. The pattern bytes are asymmetric, so lane reversal and bit reversal each produce a distinct wrong value. Back-to-back transfers without a flush show that leftover lanes of a partial word never leak into the next transfer.

// File: rtl/spi_pack_pkg.sv
package spi_pack_pkg;

    localparam int WORD_W = 32;
    localparam int LANE_W = 2;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_FETCH,
        TX_SHIFT
    } tx_state_e;

    typedef enum logic {
        RX_IDLE,
        RX_GATHER
    } rx_state_e;

    // Reverse the bits of one byte
    function automatic logic [7:0] bit_flip(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            r[i] = b[7-i];
        end
        return r;
    endfunction

    // Map a byte index inside a word to its lane
    function automatic logic [LANE_W-1:0] lane_sel(input logic [LANE_W-1:0] idx,
                                                   input logic swap);
        return swap ? ~idx : idx;
    endfunction

endpackage

// File: rtl/word_fifo.sv
module word_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [AW:0]      count;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + (AW+1)'(1);
                2'b01:   count <= count - (AW+1)'(1);
                default: count <= count;
            endcase
        end
    end

    AST_FIFO_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || flush)
        full && !pop |=> full); // R2

    AST_FIFO_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n || flush)
        empty && !push |=> empty); // R3

endmodule

// File: rtl/tx_unpacker.sv
module tx_unpacker
    import spi_pack_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              start,
    input  logic [LEN_W-1:0]  len,
    input  logic              msb_first,
    input  logic              swap,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_avail,
    output logic              pop,
    output logic [7:0]        byte_out,
    output logic              byte_valid,
    input  logic              byte_ready
);

    tx_state_e         state;
    tx_state_e         nxt;
    logic [WORD_W-1:0] hold;
    logic [LANE_W-1:0] lane;
    logic [LEN_W-1:0]  left;
    logic              take;
    logic [LANE_W-1:0] sel;
    logic [7:0]        raw;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state and outputs
    always_comb begin
        nxt        = state;
        pop        = 1'b0;
        byte_valid = (state == TX_SHIFT);
        take       = 1'b0;
        if (flush) begin
            nxt = TX_IDLE;
        end else if (start) begin
            nxt = TX_FETCH;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    nxt = TX_IDLE;
                end
                TX_FETCH: begin
                    if (left == '0) begin
                        nxt = TX_IDLE;
                    end else if (word_avail) begin
                        pop = 1'b1;
                        nxt = TX_SHIFT;
                    end
                end
                TX_SHIFT: begin
                    if (byte_ready) begin
                        take = 1'b1;
                        if (left == LEN_W'(1) || lane == '1) begin
                            nxt = TX_FETCH;
                        end
                    end
                end
                default: nxt = TX_IDLE;
            endcase
        end
    end

    // Word hold, lane index and byte count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold <= '0;
            lane <= '0;
            left <= '0;
        end else if (flush) begin
            lane <= '0;
            left <= '0;
        end else if (start) begin
            lane <= '0;
            left <= len;
        end else begin
            if (pop) begin
                hold <= word_in;
                lane <= '0;
            end
            if (take) begin
                left <= left - LEN_W'(1);
                lane <= lane + LANE_W'(1);
            end
        end
    end

    assign sel      = lane_sel(lane, swap);
    assign raw      = hold[{sel, 3'b000} +: 8];
    assign byte_out = msb_first ? raw : bit_flip(raw);

    AST_TX_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n || flush)
        byte_valid && !byte_ready && !start |=> byte_valid); // R6

    AST_TX_LEN_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> left != '0); // R6

    AST_TX_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !byte_valid); // R10

endmodule

// File: rtl/rx_packer.sv
module rx_packer
    import spi_pack_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              start,
    input  logic [LEN_W-1:0]  len,
    input  logic              msb_first,
    input  logic              swap,
    input  logic [7:0]        byte_in,
    input  logic              byte_valid,
    output logic              push,
    output logic [WORD_W-1:0] push_word
);

    rx_state_e         state;
    rx_state_e         nxt;
    logic [WORD_W-1:0] acc;
    logic [LANE_W-1:0] lane;
    logic [LEN_W-1:0]  left;
    logic              take;
    logic              last_lane;
    logic [LANE_W-1:0] sel;
    logic [7:0]        bits;
    logic [WORD_W-1:0] placed;

    assign sel       = lane_sel(lane, swap);
    assign bits      = msb_first ? byte_in : bit_flip(byte_in);
    assign placed    = acc | (WORD_W'(bits) << {sel, 3'b000});
    assign last_lane = (lane == '1) || (left == LEN_W'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state and outputs
    always_comb begin
        nxt       = state;
        take      = 1'b0;
        push      = 1'b0;
        push_word = placed;
        if (flush) begin
            nxt = RX_IDLE;
        end else if (start) begin
            nxt = RX_GATHER;
        end else begin
            unique case (state)
                RX_IDLE: begin
                    nxt = RX_IDLE;
                end
                RX_GATHER: begin
                    if (left == '0) begin
                        nxt = RX_IDLE;
                    end else if (byte_valid) begin
                        take = 1'b1;
                        push = last_lane;
                        if (left == LEN_W'(1)) begin
                            nxt = RX_IDLE;
                        end
                    end
                end
                default: nxt = RX_IDLE;
            endcase
        end
    end

    // Accumulator, lane index and byte count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            lane <= '0;
            left <= '0;
        end else if (flush) begin
            acc  <= '0;
            lane <= '0;
            left <= '0;
        end else if (start) begin
            acc  <= '0;
            lane <= '0;
            left <= len;
        end else if (take) begin
            left <= left - LEN_W'(1);
            if (last_lane) begin
                acc  <= '0;
                lane <= '0;
            end else begin
                acc  <= placed;
                lane <= lane + LANE_W'(1);
            end
        end
    end

    AST_RX_IDLE_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        state == RX_IDLE |-> !push); // R11

    AST_RX_LAST_BYTE_ENDS: assert property (@(posedge clk) disable iff (!rst_n || flush || start)
        take && left == LEN_W'(1) |=> state == RX_IDLE && acc == '0); // R9

endmodule

// File: rtl/spi_word_packer.sv
module spi_word_packer
    import spi_pack_pkg::*;
#(
    parameter int DEPTH_WORDS = 8,
    parameter int LEN_W       = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             xfer_start,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic             tx_msb_first,
    input  logic             tx_swap,
    input  logic             rx_msb_first,
    input  logic             rx_swap,
    input  logic             tx_wr_en,
    input  logic [31:0]      tx_wr_data,
    output logic             tx_full,
    output logic             tx_overflow,
    input  logic             rx_rd_en,
    output logic [31:0]      rx_rd_data,
    output logic             rx_empty,
    output logic [7:0]       tx_byte,
    output logic             tx_byte_valid,
    input  logic             tx_byte_ready,
    input  logic [7:0]       rx_byte,
    input  logic             rx_byte_valid
);

    logic [WORD_W-1:0] tx_head;
    logic              tx_empty;
    logic              tx_pop;
    logic [WORD_W-1:0] rx_head;
    logic              rx_full;
    logic              rx_push;
    logic [WORD_W-1:0] rx_push_word;

    word_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH_WORDS)) u_tx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (tx_wr_en),
        .push_data (tx_wr_data),
        .pop       (tx_pop),
        .head      (tx_head),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    tx_unpacker #(.LEN_W(LEN_W)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .start      (xfer_start),
        .len        (xfer_len),
        .msb_first  (tx_msb_first),
        .swap       (tx_swap),
        .word_in    (tx_head),
        .word_avail (!tx_empty),
        .pop        (tx_pop),
        .byte_out   (tx_byte),
        .byte_valid (tx_byte_valid),
        .byte_ready (tx_byte_ready)
    );

    rx_packer #(.LEN_W(LEN_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .start      (xfer_start),
        .len        (xfer_len),
        .msb_first  (rx_msb_first),
        .swap       (rx_swap),
        .byte_in    (rx_byte),
        .byte_valid (rx_byte_valid),
        .push       (rx_push),
        .push_word  (rx_push_word)
    );

    word_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH_WORDS)) u_rx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (rx_push),
        .push_data (rx_push_word),
        .pop       (rx_rd_en),
        .head      (rx_head),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    // Sticky overflow on a write into a full transmit queue
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_overflow <= 1'b0;
        end else if (flush) begin
            tx_overflow <= 1'b0;
        end else if (tx_wr_en && tx_full) begin
            tx_overflow <= 1'b1;
        end
    end

    assign rx_rd_data = rx_empty ? '0 : rx_head;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_overflow && !flush |=> tx_overflow); // R2

    AST_OVF_ON_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr_en && tx_full && !flush |=> tx_overflow); // R2

    AST_RX_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n || flush)
        rx_full && !rx_rd_en |=> rx_full); // R2

endmodule

// File: tb/spi_word_packer_bench.sv
`timescale 1ns/1ps
module spi_word_packer_bench;

    localparam int LEN_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush = 1'b0;
    logic             xfer_start = 1'b0;
    logic [LEN_W-1:0] xfer_len = '0;
    logic             tx_msb_first = 1'b1;
    logic             tx_swap = 1'b0;
    logic             rx_msb_first = 1'b1;
    logic             rx_swap = 1'b0;
    logic             tx_wr_en = 1'b0;
    logic [31:0]      tx_wr_data = '0;
    logic             tx_full;
    logic             tx_overflow;
    logic             rx_rd_en = 1'b0;
    logic [31:0]      rx_rd_data;
    logic             rx_empty;
    logic [7:0]       tx_byte;
    logic             tx_byte_valid;
    logic             tx_byte_ready = 1'b0;
    logic [7:0]       rx_byte = '0;
    logic             rx_byte_valid = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // {len[23:16], cfg[15:12] = tx_msb,tx_swap,rx_msb,rx_swap, seed[7:0]}
    localparam logic [23:0] VECS [6] = '{
        {8'd8,  4'b1010, 4'h0, 8'd11},
        {8'd7,  4'b0101, 4'h0, 8'd23},
        {8'd5,  4'b1100, 4'h0, 8'd40},
        {8'd32, 4'b0011, 4'h0, 8'd77},
        {8'd1,  4'b1001, 4'h0, 8'd90},
        {8'd10, 4'b0110, 4'h0, 8'd3}
    };

    always #10 clk = ~clk;

    spi_word_packer #(.DEPTH_WORDS(8), .LEN_W(LEN_W)) u_spi_word_packer (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush         (flush),
        .xfer_start    (xfer_start),
        .xfer_len      (xfer_len),
        .tx_msb_first  (tx_msb_first),
        .tx_swap       (tx_swap),
        .rx_msb_first  (rx_msb_first),
        .rx_swap       (rx_swap),
        .tx_wr_en      (tx_wr_en),
        .tx_wr_data    (tx_wr_data),
        .tx_full       (tx_full),
        .tx_overflow   (tx_overflow),
        .rx_rd_en      (rx_rd_en),
        .rx_rd_data    (rx_rd_data),
        .rx_empty      (rx_empty),
        .tx_byte       (tx_byte),
        .tx_byte_valid (tx_byte_valid),
        .tx_byte_ready (tx_byte_ready),
        .rx_byte       (rx_byte),
        .rx_byte_valid (rx_byte_valid)
    );

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [7:0] txb(input int j, input logic [7:0] s);
        return 8'(j * 29) + s;
    endfunction

    function automatic logic [7:0] rxb(input int j, input logic [7:0] s);
        return 8'(j * 53) + (s ^ 8'h5A);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks begin and end just after a falling edge
    task automatic pulse_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic host_write(input logic [31:0] w);
        tx_wr_en = 1'b1;
        tx_wr_data = w;
        @(negedge clk);
        tx_wr_en = 1'b0;
    endtask

    task automatic host_read(output logic [31:0] w);
        rx_rd_en = 1'b1;
        #1 w = rx_rd_data;
        @(negedge clk);
        rx_rd_en = 1'b0;
    endtask

    task automatic start_xfer(input int len);
        xfer_start = 1'b1;
        xfer_len = LEN_W'(len);
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic wait_tx();
        for (int i = 0; i < 20 && !tx_byte_valid; i++) @(negedge clk);
    endtask

    task automatic engine_byte(input logic [7:0] line);
        tx_byte_ready = 1'b1;
        rx_byte = line;
        rx_byte_valid = 1'b1;
        @(negedge clk);
        tx_byte_ready = 1'b0;
        rx_byte_valid = 1'b0;
    endtask

    task automatic run_vector(input int len, input logic [3:0] cfg, input logic [7:0] seed);
        int nw;
        logic [31:0] w;
        logic [31:0] exp;
        logic [7:0] eb;
        {tx_msb_first, tx_swap, rx_msb_first, rx_swap} = cfg;
        pulse_flush();
        nw = (len + 3) / 4;
        for (int k = 0; k < nw; k++) begin
            w = '0;
            for (int l = 0; l < 4; l++) begin
                int j;
                j = 4 * k + (tx_swap ? 3 - l : l);
                w[8*l +: 8] = (j < len) ? txb(j, seed) : 8'hEE;
            end
            host_write(w);
        end
        start_xfer(len);
        for (int j = 0; j < len; j++) begin
            wait_tx();
            chk("R6 tx byte present", {31'd0, tx_byte_valid}, 32'd1);
            eb = tx_msb_first ? txb(j, seed) : rev8(txb(j, seed));
            chk("R4 R5 tx byte value", {24'd0, tx_byte}, {24'd0, eb});
            engine_byte(rx_msb_first ? rxb(j, seed) : rev8(rxb(j, seed)));
        end
        repeat (2) @(negedge clk);
        chk("R6 tx stops at length", {31'd0, tx_byte_valid}, 32'd0);
        for (int k = 0; k < nw; k++) begin
            exp = '0;
            for (int l = 0; l < 4; l++) begin
                int j;
                j = 4 * k + (rx_swap ? 3 - l : l);
                exp[8*l +: 8] = (j < len) ? rxb(j, seed) : 8'h00;
            end
            host_read(w);
            chk("R7 R8 R9 rx word", w, exp);
        end
        chk("R9 rx drained", {31'd0, rx_empty}, 32'd1);
    endtask

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 tx_full", {31'd0, tx_full}, 32'd0);
        chk("R1 rx_empty", {31'd0, rx_empty}, 32'd1);
        chk("R1 tx_overflow", {31'd0, tx_overflow}, 32'd0);
        chk("R1 tx_byte_valid", {31'd0, tx_byte_valid}, 32'd0);
        chk("R1 rx_rd_data", rx_rd_data, 32'd0);

        // R3 read while empty
        host_read(w);
        chk("R3 empty read data", w, 32'd0);
        chk("R3 still empty", {31'd0, rx_empty}, 32'd1);

        // R11 receive bytes with no transfer active
        for (int i = 0; i < 5; i++) engine_byte(8'hA5);
        chk("R11 idle bytes ignored", {31'd0, rx_empty}, 32'd1);

        // Table of vectors
        for (int v = 0; v < 6; v++) begin
            run_vector(int'(VECS[v][23:16]), VECS[v][15:12], VECS[v][7:0]);
        end

        // R6 back-to-back transfers: leftover lanes discarded
        {tx_msb_first, tx_swap, rx_msb_first, rx_swap} = 4'b1010;
        pulse_flush();
        host_write(32'h03020100);
        host_write(32'hEEEEEE04);
        host_write(32'h13121110);
        start_xfer(5);
        for (int j = 0; j < 5; j++) begin
            wait_tx();
            chk("R6 first transfer byte", {24'd0, tx_byte}, 32'(j));
            engine_byte(8'h00);
        end
        start_xfer(4);
        for (int j = 0; j < 4; j++) begin
            wait_tx();
            chk("R6 second transfer byte", {24'd0, tx_byte}, 32'(8'h10 + j));
            engine_byte(8'h00);
        end

        // R2 overflow, then R10 flush mid-transfer
        pulse_flush();
        for (int k = 0; k < 8; k++) begin
            host_write({8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
        end
        chk("R2 full after eight", {31'd0, tx_full}, 32'd1);
        chk("R2 no overflow yet", {31'd0, tx_overflow}, 32'd0);
        host_write(32'hDEADBEEF);
        chk("R2 overflow set", {31'd0, tx_overflow}, 32'd1);
        start_xfer(36);
        for (int j = 0; j < 32; j++) begin
            wait_tx();
            chk("R2 queued byte", {24'd0, tx_byte}, 32'(j));
            engine_byte(8'h3C);
        end
        repeat (4) @(negedge clk);
        chk("R2 dropped word absent", {31'd0, tx_byte_valid}, 32'd0);
        chk("R2 overflow sticky", {31'd0, tx_overflow}, 32'd1);
        chk("R10 rx holds words", {31'd0, rx_empty}, 32'd0);
        pulse_flush();
        chk("R10 rx emptied", {31'd0, rx_empty}, 32'd1);
        chk("R10 overflow cleared", {31'd0, tx_overflow}, 32'd0);
        chk("R10 tx_byte_valid low", {31'd0, tx_byte_valid}, 32'd0);
        chk("R10 tx not full", {31'd0, tx_full}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R6 watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule